// File: doc/BRIEF.md
# Field Memory Write Timing Generator

This block generates the vertical write controls for a video field memory. An asynchronous field-rate sync pulse is brought into the pixel clock domain, and its rising edge starts each field. From that edge the block counts horizontal lines using a one-cycle line tick. On the first line after the edge it issues a one-line pulse that resets the memory's write address pointer. It also holds a write-enable window open between two programmed line numbers.

The start line, the end line and the 50/60 Hz mode select are captured at each sync edge. A change made during a field therefore takes effect only in the next field. The block checks the captured settings against the legal range for the selected mode. A setting outside that range, or one whose end line does not lie after its start line, keeps the write enable low for the entire field. The line count stops at the mode's line limit, so a missing sync pulse cannot make the window open a second time.

Top module: `field_write_timer`

## Requirements
- R1: After a synchronous reset, with no sync edge seen since, both `wr_addr_rst` and `wr_en` are low.
- R2: Only a low-to-high transition of `vsync_async` starts a field. If the input is held high for a whole field, the field is not restarted.
- R3: `wr_addr_rst` is high for exactly the interval between the first and second line ticks after a field start. At all other times it is low.
- R4: Let k be the number of line ticks since the field start. With valid settings, `wr_en` is high exactly when start ≤ k < end, and it changes on the clock edge that takes the tick.
- R5: In 50 Hz mode (`mode_60hz`=0), settings are valid when 1 ≤ start ≤ 310, end ≤ 311 and end > start.
- R6: In 60 Hz mode (`mode_60hz`=1), settings are valid when 1 ≤ start ≤ 260, end ≤ 261 and end > start.
- R7: With invalid settings, including end ≤ start, `wr_en` stays low for the whole field.
- R8: `mode_60hz`, `start_line` and `end_line` are sampled only at the field start. Changes during a field have no effect until the next field.
- R9: The line count stops at 311 in 50 Hz mode and at 261 in 60 Hz mode. With no further sync edge, `wr_en` never reopens, no matter how many ticks arrive.
- R10: Between the field start and the first line tick, both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| line_tick | input | 1 | One-cycle pulse per horizontal line |
| vsync_async | input | 1 | Asynchronous field-rate sync; rising edge is the reference |
| mode_60hz | input | 1 | 0 selects 50 Hz limits, 1 selects 60 Hz limits |
| start_line | input | 9 | Line count at which the write window opens |
| end_line | input | 9 | Line count at which the write window closes |
| wr_addr_rst | output | 1 | One-line write address reset pulse |
| wr_en | output | 1 | Write-enable window |

## Verification
A rise on `vsync_async` passes through two synchronizer flops. The field start is then taken on the third clock edge after the input changes. The bench raises the input just after a falling edge and waits three falling edges before it checks the R10 state. Each line tick is driven for one cycle, and both outputs are registered on the edge that samples it. The bench therefore compares them at the next falling edge against its tick count k. During random idle cycles between ticks, it checks that the outputs hold. The expected values come from the range and window rules evaluated in the bench.

// File: rtl/fwt_pkg.sv
package fwt_pkg;
  localparam int unsigned LINE_W = 9;
  typedef logic [LINE_W-1:0] line_t;

  typedef struct packed {
    logic  mode60;
    logic  ok;
    line_t first;
    line_t last;
  } field_cfg_t;
endpackage

// File: rtl/fwt_vsync_sync.sv
module fwt_vsync_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  localparam int unsigned W = STAGES + 1;
  logic [W-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[W-2:0], async_in};
  end

  assign rise = chain_q[W-2] & ~chain_q[W-1];

  // R2
  edge_single_chk: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/fwt_line_counter.sv
module fwt_line_counter
  import fwt_pkg::*;
#(
  parameter int unsigned LINES_50 = 311,
  parameter int unsigned LINES_60 = 261
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  restart,
  input  logic  tick,
  input  logic  mode60,
  output line_t cnt,
  output line_t cnt_d
);
  line_t limit;
  assign limit = mode60 ? line_t'(LINES_60) : line_t'(LINES_50);

  always_comb begin
    cnt_d = cnt;
    if (restart)                  cnt_d = '0;
    else if (tick && cnt < limit) cnt_d = cnt + line_t'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt_d;
  end

  // R9
  cnt_saturate_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= limit);
endmodule

// File: rtl/fwt_write_window.sv
module fwt_write_window
  import fwt_pkg::*;
#(
  parameter int unsigned LINES_50 = 311,
  parameter int unsigned LINES_60 = 261
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  restart,
  input  logic  tick,
  input  logic  mode60_in,
  input  line_t first_in,
  input  line_t last_in,
  input  line_t cnt_d,
  output logic  mode60_q,
  output logic  addr_rst,
  output logic  wr_en
);
  field_cfg_t cfg_q;
  logic       armed_q;
  line_t      lim_in;
  logic       legal;

  assign lim_in = mode60_in ? line_t'(LINES_60) : line_t'(LINES_50);
  assign legal  = (first_in >= line_t'(1)) && (first_in < lim_in) &&
                  (last_in <= lim_in) && (last_in > first_in);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q    <= '0;
      armed_q  <= 1'b0;
      addr_rst <= 1'b0;
      wr_en    <= 1'b0;
    end else begin
      if (restart) begin
        cfg_q.mode60 <= mode60_in;
        cfg_q.ok     <= legal;
        cfg_q.first  <= first_in;
        cfg_q.last   <= last_in;
        armed_q      <= 1'b1;
        addr_rst     <= 1'b0;
      end else if (tick) begin
        addr_rst <= armed_q;
        armed_q  <= 1'b0;
      end
      wr_en <= cfg_q.ok && !restart &&
               (cnt_d >= cfg_q.first) && (cnt_d < cfg_q.last);
    end
  end

  assign mode60_q = cfg_q.mode60;

  // R4
  wen_rise_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_en) |-> $past(tick));
  // R7
  wen_blocked_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_q.ok |-> !wr_en);
  // R3
  rst_pulse_tick_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(addr_rst) |-> ($past(tick) || $past(restart)));
endmodule

// File: rtl/field_write_timer.sv
module field_write_timer
  import fwt_pkg::*;
#(
  parameter int unsigned LINES_50    = 311,
  parameter int unsigned LINES_60    = 261,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_tick,
  input  logic              vsync_async,
  input  logic              mode_60hz,
  input  logic [LINE_W-1:0] start_line,
  input  logic [LINE_W-1:0] end_line,
  output logic              wr_addr_rst,
  output logic              wr_en
);
  logic  field_start;
  logic  mode60_q;
  line_t cnt, cnt_d;

  fwt_vsync_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(vsync_async), .rise(field_start)
  );

  fwt_line_counter #(.LINES_50(LINES_50), .LINES_60(LINES_60)) u_cnt (
    .clk(clk), .rst(rst), .restart(field_start), .tick(line_tick),
    .mode60(mode60_q), .cnt(cnt), .cnt_d(cnt_d)
  );

  fwt_write_window #(.LINES_50(LINES_50), .LINES_60(LINES_60)) u_win (
    .clk(clk), .rst(rst), .restart(field_start), .tick(line_tick),
    .mode60_in(mode_60hz), .first_in(start_line), .last_in(end_line),
    .cnt_d(cnt_d), .mode60_q(mode60_q), .addr_rst(wr_addr_rst), .wr_en(wr_en)
  );

  // R3
  rst_pulse_line1_chk: assert property (@(posedge clk) disable iff (rst)
    wr_addr_rst |-> (cnt == line_t'(1)));
  // R10
  quiet_at_start_chk: assert property (@(posedge clk) disable iff (rst)
    field_start |=> (!wr_en && !wr_addr_rst));
endmodule

// File: tb/field_write_timer_tb_top.sv
module field_write_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       line_tick = 1'b0;
  logic       vsync_async = 1'b0;
  logic       mode_60hz = 1'b0;
  logic [8:0] start_line = '0;
  logic [8:0] end_line = '0;
  logic       wr_addr_rst, wr_en;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  int cur_m, cur_s, cur_e, k;

  always #5 clk = ~clk;

  field_write_timer dut_i (
    .clk(clk), .rst(rst), .line_tick(line_tick), .vsync_async(vsync_async),
    .mode_60hz(mode_60hz), .start_line(start_line), .end_line(end_line),
    .wr_addr_rst(wr_addr_rst), .wr_en(wr_en)
  );

  function automatic int lim_of(int m);
    return (m != 0) ? 261 : 311;
  endfunction

  function automatic bit legal_of(int m, int s, int e);
    return (s >= 1) && (s < lim_of(m)) && (e <= lim_of(m)) && (e > s);
  endfunction

  function automatic bit exp_we(int m, int s, int e, int kk);
    int ks = (kk > lim_of(m)) ? lim_of(m) : kk;
    return legal_of(m, s, e) && (ks >= s) && (ks < e);
  endfunction

  task automatic chk(input logic act, input logic exp, input string req, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b (k=%0d s=%0d e=%0d m=%0d)",
               req, what, act, exp, k, cur_s, cur_e, cur_m);
    end
  endtask

  task automatic check_outs(input string req);
    chk(wr_addr_rst, (k == 1), "R3", "wr_addr_rst");
    chk(wr_en, exp_we(cur_m, cur_s, cur_e, k), req, "wr_en");
  endtask

  task automatic start_field(input int m, input int s, input int e, input bit hold);
    @(negedge clk);
    vsync_async = 1'b0;
    mode_60hz = m[0]; start_line = s[8:0]; end_line = e[8:0];
    repeat (3) @(negedge clk);
    vsync_async = 1'b1;
    repeat (3) @(negedge clk);
    if (!hold) vsync_async = 1'b0;
    cur_m = m; cur_s = s; cur_e = e; k = 0;
    chk(wr_addr_rst, 1'b0, "R10", "wr_addr_rst at start");
    chk(wr_en, 1'b0, "R10", "wr_en at start");
  endtask

  task automatic one_tick(input string req);
    line_tick = 1'b1;
    @(negedge clk);
    line_tick = 1'b0;
    k++;
    check_outs(req);
    repeat ($urandom_range(0, 2)) begin
      @(negedge clk);
      check_outs(req);
    end
  endtask

  task automatic run_field(input string req, input int extra);
    for (int i = 0; i < lim_of(cur_m) + extra; i++) begin
      if (i == 3) begin
        mode_60hz = 1'($urandom);
        start_line = 9'($urandom);
        end_line = 9'($urandom);
      end
      one_tick((i == 3) ? "R8" : req);
    end
  endtask

  function automatic string req_for(int m, int s, int e);
    if (!legal_of(m, s, e)) return "R7";
    return (m != 0) ? "R6" : "R5";
  endfunction

  initial begin
    process::self().srandom(32'd1234);
    cur_m = 0; cur_s = 0; cur_e = 0; k = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(wr_addr_rst, 1'b0, "R1", "wr_addr_rst after reset");
    chk(wr_en, 1'b0, "R1", "wr_en after reset");
    for (int i = 0; i < 20; i++) begin
      line_tick = 1'b1; @(negedge clk); line_tick = 1'b0; @(negedge clk);
    end
    chk(wr_en, 1'b0, "R1", "wr_en before first sync");

    start_field(0, 1, 311, 0);   run_field("R5", 2);
    start_field(1, 1, 261, 0);   run_field("R6", 2);
    start_field(0, 310, 311, 0); run_field("R5", 2);
    start_field(0, 40, 200, 1);  run_field("R2", 3);
    start_field(0, 0, 5, 0);     run_field("R7", 1);
    start_field(0, 5, 312, 0);   run_field("R7", 1);
    start_field(1, 10, 262, 0);  run_field("R7", 1);
    start_field(1, 270, 280, 0); run_field("R6", 1);
    start_field(0, 20, 20, 0);   run_field("R7", 1);
    start_field(0, 30, 10, 0);   run_field("R7", 1);
    start_field(1, 100, 260, 0); run_field("R4", 1);

    for (int f = 0; f < 8; f++) begin
      int m = int'($urandom_range(0, 1));
      int s = int'($urandom_range(0, 320));
      int e = int'($urandom_range(0, 320));
      if (f % 2 == 0) begin
        s = int'($urandom_range(1, lim_of(m) - 1));
        e = int'($urandom_range(s + 1, lim_of(m)));
      end
      start_field(m, s, e, 0);
      run_field(req_for(m, s, e), 1);
    end

    start_field(0, 2, 300, 0);
    run_field("R4", 0);
    for (int i = 0; i < 600; i++) one_tick("R9");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule